// File: doc/BRIEF.md
# Serial Memory Write-Enable Latch Controller

This block is the instruction front end of a serial-bus memory slave. While the chip-select input is low it gathers an 8-bit instruction from the serial data line, one bit per rising serial clock edge, most significant bit first. It owns the single write-enable latch that must be set before any operation that changes the memory or its status register. It also grants or refuses the two modifying commands as their instruction bytes arrive.

The latch is set by exactly one instruction, and only once chip select returns high after a frame of exactly eight bits. Five events clear it: reset, the disable instruction, the completion of a memory write, the completion of a status write, and a low level on the write-protect pin. Each accepted modifying command therefore needs its own fresh enable. All pins pass through a synchronizer of configurable depth and are sampled on the system clock.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset `wel` and `write_permit` are 0, and no start pulse appears until a command is received.
- R2: Opcode 0x06, received MSB first on rising `sclk` edges, sets `wel` to 1 when `cs_n` rises after exactly eight bits.
- R3: Opcode 0x04, in a frame of exactly eight bits, clears `wel` when `cs_n` rises.
- R4: A frame of fewer or more than eight bits is discarded when `cs_n` rises, and `wel` keeps its value.
- R5: `wel` does not change while `cs_n` stays low, even after all eight bits of 0x06 or 0x04 have arrived.
- R6: Opcode 0x02 (memory write) gives one `mem_go` pulse after its eighth bit when `write_permit` is 1. With the latch clear it gives no pulse, and `wel` stays 0.
- R7: Opcode 0x01 (status write) gives one `stat_go` pulse under the same condition. It is ignored while the latch is clear.
- R8: A one-cycle pulse on `wr_done` or on `sr_done` clears `wel`.
- R9: While `wp_n` is low, `wel` and `write_permit` are 0, and 0x06 has no effect. Raising `wp_n` again does not restore the latch.
- R10: When a clear event and the commit of 0x06 fall on the same clock edge, the clear wins and `wel` ends at 0.
- R11: Other opcodes, for example 0x03, leave `wel` unchanged and give no start pulse.
- R12: The bit counter restarts whenever `cs_n` is high, so a full frame that follows an aborted partial frame is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| mosi | input | 1 | Serial instruction input |
| wp_n | input | 1 | Write protect, active low |
| wr_done | input | 1 | One-cycle pulse: a memory write has finished |
| sr_done | input | 1 | One-cycle pulse: a status write has finished |
| wel | output | 1 | Write-enable latch state |
| write_permit | output | 1 | Latch set and protect released |
| mem_go | output | 1 | One-cycle start of an accepted memory write |
| stat_go | output | 1 | One-cycle start of an accepted status write |

## Verification
Two latch functions can fall in the same cycle: the commit of the enable instruction when chip select rises, and the clearing by a completion pulse. The bench provokes this by timing `wr_done` to land on the clock edge where the synchronized chip-select rise is acted on, and it expects the latch to end clear. A control case moves the pulse one cycle earlier, where the latch must end set. That pair shows the priority order itself, and not just the clearing.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;
   localparam int OPC_W = 8;
   typedef logic [OPC_W-1:0] opc_t;

   localparam opc_t OPC_SET_EN  = 8'h06;
   localparam opc_t OPC_CLR_EN  = 8'h04;
   localparam opc_t OPC_MEM_WR  = 8'h02;
   localparam opc_t OPC_STAT_WR = 8'h01;
endpackage

// File: rtl/spi_wel_sync.sv
module spi_wel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sclk_i,
   input  logic mosi_i,
   input  logic wp_n_i,
   output logic cs_q,
   output logic mosi_q,
   output logic wp_q,
   output logic sclk_rise,
   output logic cs_rise
);
   localparam int W = 4;
   localparam logic [W-1:0] IDLE = 4'b1001; // {wp_n, mosi, sclk, cs_n}

   logic [W-1:0] pins_in, pins_q;
   logic         sclk_d, cs_d;

   assign pins_in = {wp_n_i, mosi_i, sclk_i, cs_n_i};

   if (STAGES < 0 || STAGES > 8) begin : g_bad_depth
      $error("spi_wel_sync: STAGES must be 0..8");
   end

   if (STAGES == 0) begin : g_direct
      assign pins_q = pins_in;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
         end else begin
            stg[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign pins_q = stg[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= pins_q[1];
         cs_d   <= pins_q[0];
      end
   end

   assign cs_q      = pins_q[0];
   assign mosi_q    = pins_q[2];
   assign wp_q      = pins_q[3];
   assign sclk_rise = pins_q[1] & ~sclk_d;
   assign cs_rise   = pins_q[0] & ~cs_d;
endmodule

// File: rtl/spi_wel_shift.sv
module spi_wel_shift #(
   parameter int BITS = 8,
   localparam int CW = $clog2(BITS + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_q,
   input  logic            sclk_rise,
   input  logic            mosi_q,
   output logic [BITS-1:0] shreg,
   output logic            exact,
   output logic            byte_done
);
   localparam logic [CW-1:0] LAST = CW'(BITS - 1);
   localparam logic [CW-1:0] FULL = CW'(BITS);
   localparam logic [CW-1:0] OVER = CW'(BITS + 1);

   logic [CW-1:0] cnt;

   if (BITS < 2) begin : g_bad_bits
      $error("spi_wel_shift: BITS must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         cnt       <= '0;
         byte_done <= 1'b0;
      end else if (cs_q) begin
         shreg     <= '0;
         cnt       <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sclk_rise) begin
            if (cnt < FULL) shreg <= {shreg[BITS-2:0], mosi_q};
            if (cnt != OVER) cnt <= cnt + 1'b1;
            byte_done <= (cnt == LAST);
         end
      end
   end

   assign exact = (cnt == FULL);

   assert_idle_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> (cnt == '0 && !byte_done));
   assert_done_on_eighth_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> exact);
endmodule

// File: rtl/spi_wel_cmd.sv
module spi_wel_cmd
   import spi_wel_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic byte_done,
   input  opc_t opcode,
   input  logic permit,
   output logic mem_go,
   output logic stat_go
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_go  <= 1'b0;
         stat_go <= 1'b0;
      end else begin
         mem_go  <= byte_done && permit && (opcode == OPC_MEM_WR);
         stat_go <= byte_done && permit && (opcode == OPC_STAT_WR);
      end
   end

   assert_mem_go_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_go |=> !mem_go);
   assert_stat_go_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_go |=> !stat_go);
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
   import spi_wel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   input  logic wp_n,
   input  logic wr_done,
   input  logic sr_done,
   output logic wel,
   output logic write_permit,
   output logic mem_go,
   output logic stat_go
);
   logic cs_q, mosi_q, wp_q, sclk_rise, cs_rise;
   logic exact, byte_done;
   opc_t opcode;
   logic wel_q;

   spi_wel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi), .wp_n_i(wp_n),
      .cs_q(cs_q), .mosi_q(mosi_q), .wp_q(wp_q),
      .sclk_rise(sclk_rise), .cs_rise(cs_rise)
   );

   spi_wel_shift #(.BITS(OPC_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_q(cs_q), .sclk_rise(sclk_rise), .mosi_q(mosi_q),
      .shreg(opcode), .exact(exact), .byte_done(byte_done)
   );

   // Clear events outrank the commit of the enable instruction.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (!wp_q || wr_done || sr_done) begin
         wel_q <= 1'b0;
      end else if (cs_rise && exact) begin
         if (opcode == OPC_SET_EN)      wel_q <= 1'b1;
         else if (opcode == OPC_CLR_EN) wel_q <= 1'b0;
      end
   end

   assign write_permit = wel_q & wp_q;
   assign wel          = wel_q;

   spi_wel_cmd u_cmd (
      .clk(clk), .rst_n(rst_n),
      .byte_done(byte_done), .opcode(opcode), .permit(write_permit),
      .mem_go(mem_go), .stat_go(stat_go)
   );

   assert_set_only_by_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> $past(cs_rise && exact && opcode == OPC_SET_EN));
   assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done || sr_done) |=> !wel_q);
   assert_protect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_q |=> !wel_q);
   assert_hold_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_rise && wp_q && !wr_done && !sr_done) |=> $stable(wel_q));
   assert_bad_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !exact && wp_q && !wr_done && !sr_done) |=> $stable(wel_q));
   assert_go_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_go || stat_go) |-> $past(write_permit));
endmodule

// File: tb/sim_spi_wel_ctrl.sv
module sim_spi_wel_ctrl;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
   logic wr_done = 1'b0, sr_done = 1'b0;
   logic wel, write_permit, mem_go, stat_go;

   int checks = 0, errors = 0;
   int mem_n = 0, stat_n = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   spi_wel_ctrl #(.SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
      .wp_n(wp_n), .wr_done(wr_done), .sr_done(sr_done),
      .wel(wel), .write_permit(write_permit), .mem_go(mem_go), .stat_go(stat_go)
   );

   always @(posedge clk) begin
      if (mem_go)  mem_n  <= mem_n + 1;
      if (stat_go) stat_n <= stat_n + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic open_bits(input logic [15:0] val, input int n);
      @(negedge clk) cs_n = 1'b0;
      idle(4);
      for (int i = n - 1; i >= 0; i--) begin
         mosi = val[i];
         idle(4);
         sclk = 1'b1;
         idle(4);
         sclk = 1'b0;
      end
      idle(4);
   endtask

   task automatic close_frame();
      cs_n = 1'b1;
      idle(12);
   endtask

   task automatic frame(input logic [15:0] val, input int n);
      open_bits(val, n);
      close_frame();
   endtask

   task automatic pulse_wr();
      wr_done = 1'b1; @(negedge clk) wr_done = 1'b0; idle(4);
   endtask

   task automatic pulse_sr();
      sr_done = 1'b1; @(negedge clk) sr_done = 1'b0; idle(4);
   endtask

   task automatic t_reset();
      check("R1 wel after reset", wel, 0);
      check("R1 permit after reset", write_permit, 0);
      check("R1 no start pulses", mem_n + stat_n, 0);
   endtask

   task automatic t_set_clear();
      frame(16'h06, 8);
      check("R2 enable sets latch", wel, 1);
      check("R2 permit follows latch", write_permit, 1);
      frame(16'h04, 8);
      check("R3 disable clears latch", wel, 0);
   endtask

   task automatic t_hold_in_frame();
      open_bits(16'h06, 8);
      idle(10);
      check("R5 no change before cs rises (set)", wel, 0);
      close_frame();
      check("R5 takes effect at cs rise", wel, 1);
      open_bits(16'h04, 8);
      idle(10);
      check("R5 no change before cs rises (clear)", wel, 1);
      close_frame();
      check("R3 disable after hold", wel, 0);
   endtask

   task automatic t_bad_length();
      frame(16'h03, 7);              // seven bits of an enable pattern (0000011)
      check("R4 seven-bit frame ignored", wel, 0);
      frame({7'h0, 8'h06, 1'b0}, 9); // 0x06 then one extra bit
      check("R4 nine-bit frame ignored", wel, 0);
      frame(16'h06, 8);
      frame({7'h0, 8'h04, 1'b1}, 9);
      check("R4 long disable leaves latch set", wel, 1);
      frame(16'h02, 4);
      check("R4 short frame keeps latch set", wel, 1);
      frame(16'h04, 8);
   endtask

   task automatic t_restart();
      frame(16'h5, 3);
      frame(16'h06, 8);
      check("R12 frame after partial frame decodes", wel, 1);
      frame(16'h04, 8);
   endtask

   task automatic t_modify();
      int m0, s0;
      m0 = mem_n; s0 = stat_n;
      frame(16'h02, 8);
      check("R6 write ignored while latch clear", mem_n - m0, 0);
      frame(16'h01, 8);
      check("R7 status write ignored while latch clear", stat_n - s0, 0);
      check("R6 latch stays clear", wel, 0);
      frame(16'h06, 8);
      frame(16'h02, 8);
      check("R6 write accepted once", mem_n - m0, 1);
      check("R6 no status pulse on write", stat_n - s0, 0);
      pulse_wr();
      check("R8 write completion clears", wel, 0);
      frame(16'h06, 8);
      frame(16'h01, 8);
      check("R7 status write accepted once", stat_n - s0, 1);
      pulse_sr();
      check("R8 status completion clears", wel, 0);
   endtask

   task automatic t_other_opcode();
      int m0, s0;
      m0 = mem_n; s0 = stat_n;
      frame(16'h06, 8);
      frame(16'h03, 8);
      check("R11 other opcode leaves latch", wel, 1);
      check("R11 other opcode no pulse", (mem_n - m0) + (stat_n - s0), 0);
      frame(16'h04, 8);
   endtask

   task automatic t_protect();
      int m0;
      m0 = mem_n;
      frame(16'h06, 8);
      @(negedge clk) wp_n = 1'b0;
      idle(6);
      check("R9 protect low clears latch", wel, 0);
      check("R9 protect low drops permit", write_permit, 0);
      frame(16'h06, 8);
      check("R9 enable ignored while protected", wel, 0);
      frame(16'h02, 8);
      check("R9 no write while protected", mem_n - m0, 0);
      @(negedge clk) wp_n = 1'b1;
      idle(6);
      check("R9 release does not restore", wel, 0);
      frame(16'h06, 8);
      check("R9 enable works after release", wel, 1);
      frame(16'h04, 8);
   endtask

   task automatic t_collision();
      // Clear pulse lands on the commit edge: clear wins.
      open_bits(16'h06, 8);
      cs_n = 1'b1;
      idle(SYNC);
      wr_done = 1'b1;
      @(negedge clk) wr_done = 1'b0;
      idle(10);
      check("R10 clear beats same-edge enable", wel, 0);
      // Control: pulse one edge earlier, commit afterwards sets the latch.
      open_bits(16'h06, 8);
      cs_n = 1'b1;
      idle(SYNC - 1);
      wr_done = 1'b1;
      @(negedge clk) wr_done = 1'b0;
      idle(10);
      check("R10 earlier clear then enable sets", wel, 1);
      frame(16'h04, 8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_set_clear();
      t_hold_in_frame();
      t_bad_length();
      t_restart();
      t_modify();
      t_other_opcode();
      t_protect();
      t_collision();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule